// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timer

This block drives the two gates of the secondary-side synchronous rectifiers in a resonant converter. In its normal mode it works from a single digital reference that follows the square-wave voltage at one rectifier drain: the high half of that wave belongs to rectifier A, the low half to rectifier B. For each rectifier it waits a programmable number of ticks after the start of its half-cycle before turning the gate on, so that reverse recovery has finished. It also turns the gate off a programmable number of ticks before the half-cycle is expected to end. The expected end is predicted from the measured length of that rectifier's previous half-cycle, so the timing follows the switching frequency on either side of resonance without any setting that depends on frequency.

A second mode takes the two primary gate timing signals as the half-cycle sources instead: rectifier A follows the high-side primary on time and rectifier B the low-side one. The same delays apply. Each rectifier's conduction then lies inside the matching primary on time, which lets the rectifiers run through soft start, before the drain reference is meaningful. Delays count the same clock tick as the primary dead time. An enable input forces both gates low, and an interlock keeps the two gates from ever being high together.

Top module: `sr_gate_timer`

## Requirements
- R1: With `use_primary`=0, `ref_in`=1 is rectifier A's half-cycle and `ref_in`=0 is rectifier B's. Let p be the number of clock edges since the edge that first sampled the half-cycle (p=0 at that edge). The gate is high in the cycle after the edge at position p exactly when p >= ON and p+OFF < L, where ON and OFF are that rectifier's delays and L is the length in cycles of its previous half-cycle.
- R2: A gate never rises before its turn-on delay has elapsed: positions p < ON keep it low.
- R3: The turn-off point is taken from the measured length of the same rectifier's previous half-cycle, so it tracks half-cycle lengths that change from one cycle to the next.
- R4: When ON+OFF >= L the conduction window is empty, and that rectifier stays low for the whole half-cycle.
- R5: After reset, a rectifier stays low until one of its half-cycles has been measured completely.
- R6: With `use_primary`=1, `pri_hi`=1 is rectifier A's half-cycle and `pri_lo`=1 is rectifier B's. When neither is high, both gates are low. `ref_in` has no effect in this mode.
- R7: A change of `use_primary` discards both measured lengths. Both gates are low from the second cycle after the change until a half-cycle has been measured again in the new mode.
- R8: While `en`=0 both gates are low from the next cycle. Measurement continues, so gating resumes on the first cycle after `en` returns to 1.
- R9: `sr_a` and `sr_b` are never high in the same cycle.
- R10: While reset is asserted both gates are low.
- R11: When a half-cycle ends early, the gate drops in the cycle after the edge that sampled the end of the half-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, shared with the primary dead-time counter |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Gate enable; 0 forces both gates low |
| use_primary | input | 1 | 0: drain reference timing, 1: primary timing |
| ref_in | input | 1 | Digital drain reference; 1 = rectifier A half-cycle |
| pri_hi | input | 1 | High-side primary gate timing |
| pri_lo | input | 1 | Low-side primary gate timing |
| a_on_dly | input | DLY_W | Rectifier A turn-on delay in ticks |
| a_off_dly | input | DLY_W | Rectifier A turn-off advance in ticks |
| b_on_dly | input | DLY_W | Rectifier B turn-on delay in ticks |
| b_off_dly | input | DLY_W | Rectifier B turn-off advance in ticks |
| sr_a | output | 1 | Rectifier A gate |
| sr_b | output | 1 | Rectifier B gate |

## Verification
The hardest situations to reach are those where a stored half-cycle length and the current half-cycle disagree. This happens when a half-cycle ends before the predicted turn-off point, and when a mode change arrives while lengths from the other source are still stored. The stimulus drives half-cycles of varying length back to back, so that each prediction comes from a different previous length. It also moves the delays so that the window lands exactly on the empty boundary, and switches mode on a half-cycle boundary. A bench-side model of the window rule turns each driven cycle into an expected gate pair, which goes into the scoreboard.

// File: rtl/sr_gate_timer.sv
`timescale 1ns/1ps
module sr_gate_timer #(
  parameter int CNT_W = 10,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             use_primary,
  input  logic             ref_in,
  input  logic             pri_hi,
  input  logic             pri_lo,
  input  logic [DLY_W-1:0] a_on_dly,
  input  logic [DLY_W-1:0] a_off_dly,
  input  logic [DLY_W-1:0] b_on_dly,
  input  logic [DLY_W-1:0] b_off_dly,
  output logic             sr_a,
  output logic             sr_b
);
  localparam int SW = ((CNT_W > DLY_W) ? CNT_W : DLY_W) + 1;

  logic [1:0]       src, win;
  logic [DLY_W-1:0] on_d  [2];
  logic [DLY_W-1:0] off_d [2];
  logic             mode_q;
  logic             mode_chg;

  assign src[0]   = use_primary ? pri_hi : ref_in;
  assign src[1]   = use_primary ? pri_lo : ~ref_in;
  assign on_d[0]  = a_on_dly;
  assign on_d[1]  = b_on_dly;
  assign off_d[0] = a_off_dly;
  assign off_d[1] = b_off_dly;
  assign mode_chg = use_primary != mode_q;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= use_primary;

  for (genvar c = 0; c < 2; c++) begin : chan
    logic             s_q;
    logic [CNT_W-1:0] cnt_q, len_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_q   <= 1'b0;
        cnt_q <= '0;
        len_q <= '0;
      end else begin
        s_q <= src[c];
        if (mode_chg) begin
          cnt_q <= '0;
          len_q <= '0;
        end else if (!s_q) begin
          if (cnt_q != '0) len_q <= cnt_q;
          cnt_q <= '0;
        end else if (cnt_q != '1) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign win[c] = s_q && (SW'(cnt_q) >= SW'(on_d[c]))
                        && (SW'(cnt_q) + SW'(off_d[c]) < SW'(len_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_a <= 1'b0;
      sr_b <= 1'b0;
    end else begin
      sr_a <= en && win[0] && !win[1];
      sr_b <= en && win[1] && !win[0];
    end
  end

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_a && sr_b)); // R9
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sr_a && !sr_b)); // R8
  AST_A_NEEDS_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (chan[0].len_q == '0) |=> !sr_a); // R5
  AST_B_NEEDS_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (chan[1].len_q == '0) |=> !sr_b); // R5
  AST_MODE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> ##2 (!sr_a && !sr_b)); // R7
endmodule

// File: tb/sr_gate_timer_tb_top.sv
`timescale 1ns/1ps
module sr_gate_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, use_primary = 1'b0;
  logic ref_in = 1'b0, pri_hi = 1'b0, pri_lo = 1'b0;
  logic [7:0] a_on = 8'd0, a_off = 8'd0, b_on = 8'd0, b_off = 8'd0;
  logic sr_a, sr_b;

  always #10 clk = ~clk;

  sr_gate_timer #(.CNT_W(10), .DLY_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .use_primary(use_primary),
    .ref_in(ref_in), .pri_hi(pri_hi), .pri_lo(pri_lo),
    .a_on_dly(a_on), .a_off_dly(a_off), .b_on_dly(b_on), .b_off_dly(b_off),
    .sr_a(sr_a), .sr_b(sr_b));

  typedef struct { bit a; bit b; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  int meas[2] = '{0, 0};
  int st = 2, pos = 0;
  int pend_ch = 0, pend_len = 0;
  bit pend_v = 0, last_mode = 0;

  function automatic bit expv(int w);
    int on, off;
    on  = (w == 0) ? int'(a_on)  : int'(b_on);
    off = (w == 0) ? int'(a_off) : int'(b_off);
    if (!en || st != w) return 1'b0;
    return (pos >= on) && (pos + off < meas[w]);
  endfunction

  task automatic set_dly(input int ao, input int af, input int bo, input int bf);
    a_on = 8'(ao); a_off = 8'(af); b_on = 8'(bo); b_off = 8'(bf);
  endtask

  // ch: 0 = rectifier A half, 1 = rectifier B half, 2 = primary dead gap
  task automatic phase(input int ch, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      if (!use_primary) ref_in = (ch == 0);
      else begin
        pri_hi = (ch == 0);
        pri_lo = (ch == 1);
        ref_in = i[0];
      end
      it.a = expv(0); it.b = expv(1); it.tag = tag;
      q.push_back(it);
      if (i == 0) begin
        if (use_primary != last_mode) begin
          meas[0] = 0; meas[1] = 0; pend_v = 0; last_mode = use_primary;
        end else if (pend_v) begin
          meas[pend_ch] = pend_len; pend_v = 0;
        end
      end
      st = ch; pos = i;
      @(negedge clk);
    end
    if (ch < 2) begin pend_v = 1; pend_ch = ch; pend_len = n; end
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (sr_a !== it.a || sr_b !== it.b) begin
        fails++;
        $display("FAIL %s: sr_a/sr_b=%b%b expected %b%b at %0t", it.tag, sr_a, sr_b, it.a, it.b, $time);
      end
      checks++;
      if (sr_a && sr_b) begin
        fails++;
        $display("FAIL R9: sr_a/sr_b=%b%b expected not both high", sr_a, sr_b);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (sr_a !== 1'b0 || sr_b !== 1'b0) begin
      fails++;
      $display("FAIL R10: reset gates %b%b expected 00", sr_a, sr_b);
    end
    rst_n = 1'b1;
    // reference mode, staggered delays
    set_dly(2, 3, 1, 2);
    phase(1, 10, "R5"); phase(0, 10, "R5");
    phase(1, 10, "R1"); phase(0, 10, "R2");
    phase(1, 12, "R1"); phase(0, 16, "R3");
    phase(1, 8, "R3");  phase(0, 6, "R11");
    phase(1, 9, "R3");
    // empty and boundary windows
    set_dly(6, 4, 1, 2); phase(0, 10, "R4");
    phase(1, 9, "R3");
    set_dly(5, 5, 1, 2); phase(0, 10, "R4");
    phase(1, 9, "R1");
    set_dly(5, 4, 1, 2); phase(0, 10, "R2");
    // enable
    en = 1'b0; phase(1, 9, "R8"); phase(0, 10, "R8");
    en = 1'b1; phase(1, 9, "R8"); phase(0, 10, "R8");
    // zero delays
    set_dly(0, 0, 0, 0);
    phase(1, 9, "R1"); phase(0, 10, "R1"); phase(1, 7, "R11");
    // primary-timing mode
    use_primary = 1'b1; set_dly(1, 1, 1, 1);
    phase(0, 8, "R7"); phase(2, 2, "R6");
    phase(1, 8, "R7"); phase(2, 2, "R6");
    phase(0, 8, "R6"); phase(2, 1, "R6");
    phase(1, 8, "R6"); phase(2, 3, "R6");
    phase(0, 12, "R3"); phase(2, 2, "R6");
    phase(1, 5, "R11"); phase(2, 2, "R6");
    // back to reference mode
    use_primary = 1'b0; ref_in = 1'b0; pri_hi = 1'b0; pri_lo = 1'b0;
    phase(0, 10, "R7"); phase(1, 10, "R7");
    phase(0, 10, "R1"); phase(1, 10, "R1");
    phase(0, 4, "R1");
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d expectations left unchecked, expected 0", q.size());
    end
    finish_run();
  end
endmodule